// File: doc/BRIEF.md
# Program Counter and Branch-Join Sequencer

This block owns the 64-bit program counter of a scalar instruction sequencer together with a small control-stack pointer. Each cycle in which the strobe `op_valid` is high and the block is idle, it carries out one instruction given by `op_code`. Some codes leave the counter at the next instruction. Others copy that next-instruction address to a 64-bit destination, jump to a source operand, jump to a trap-return address, or rejoin a divergent branch.

The join compares the stack pointer with the source operand. If the two match, execution falls through. If they differ, the pointer steps down by one. The block then restores a saved execution mask and a saved program counter from an internal array of 32-bit words. Slot `c` occupies words `4c` to `4c+3`. The array reads 64 bits per cycle, so a pop takes two cycles, and the block reports `busy` while it runs. Entries are pushed by logic outside the block. For verification, a preload port writes words into the array and sets the stack pointer.

Top module: `pc_join_seq`

## Requirements
- R1: After a synchronous active-low reset, `pc` equals parameter RESET_PC, `csp` is 0, and `dst_we`, `exec_we`, `busy` and `underflow` are 0.
- R2: Op codes 0, 6 and 7 advance `pc` by 4 at the accepting edge and write nothing.
- R3: Op code 1 (read PC) advances `pc` by 4. After that edge, `dst_we` is high for one cycle and `dst_data` holds the old `pc` + 4.
- R4: Op code 2 (set PC) loads `src_operand` into `pc` and does not write the destination.
- R5: Op code 3 (swap PC) loads `src_operand` into `pc`. At the same edge it presents the old `pc` + 4 on `dst_data` with `dst_we` high.
- R6: Op code 4 (trap return) loads `trap_addr` into `pc`.
- R7: Op code 5 (join) with `src_operand` equal to the zero-extended `csp` advances `pc` by 4 and leaves `csp` unchanged. It does not write the mask.
- R8: A join whose `src_operand` differs from `csp`, with `csp` non-zero, decrements `csp` at the accepting edge and raises `busy`. Let `c` be the decremented value. One cycle later `exec_we` pulses with `exec_data` = {word 4c+1, word 4c}. One cycle after that `pc` = {word 4c+3, word 4c+2} and `busy` falls.
- R9: While `busy` is high, `op_valid` is ignored: `pc` does not advance and `dst_we` stays 0.
- R10: A join whose `src_operand` differs from `csp`, with `csp` at 0, pulses `underflow` for one cycle. It leaves `pc` and `csp` unchanged and does not raise `busy`.
- R11: `pre_we` writes `pre_data` into word `pre_addr`. `pre_csp_we` loads `pre_csp` into `csp` when the block is idle and `op_valid` is low.
- R12: The join compares all 64 bits of `src_operand`. An operand that matches `csp` in its low bits but has any upper bit set counts as a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Instruction strobe |
| op_code | input | 3 | Instruction select (0..7) |
| src_operand | input | 64 | Source operand |
| trap_addr | input | 64 | Trap-return address |
| pre_we | input | 1 | Test port: word write enable |
| pre_addr | input | CSP_W+2 | Test port: word index |
| pre_data | input | 32 | Test port: word data |
| pre_csp_we | input | 1 | Test port: stack pointer load |
| pre_csp | input | CSP_W | Test port: stack pointer value |
| pc | output | 64 | Current program counter |
| dst_data | output | 64 | Destination result |
| dst_we | output | 1 | Destination write enable |
| exec_data | output | 64 | Restored execution mask |
| exec_we | output | 1 | Execution mask write enable |
| csp | output | CSP_W | Control-stack pointer |
| busy | output | 1 | Pop in progress |
| underflow | output | 1 | Join pop attempted with empty stack |

## Verification
The bench builds the block with CSP_W = 3, which gives eight slots in 32 words, and with RESET_PC = 0x100, so the reset value cannot be mistaken for zero. With the small array every word can be preloaded, and the stack pointer can start at its maximum value of 7, so the pops read the top slots. The bench also issues a join whose operand matches `csp` in its low bits but differs in its upper bits, which makes the full-width compare visible.

// File: rtl/pcj_pkg.sv
// Package: shared opcode encoding and constants for the PC/join sequencer.
// Assumes: opcodes not listed are treated as plain step instructions.
package pcj_pkg;
    localparam int          WORD_W  = 32;
    localparam int          PC_W    = 64;
    localparam logic [63:0] PC_STEP = 64'd4;

    typedef enum logic [2:0] {
        OP_STEP    = 3'd0,
        OP_GETPC   = 3'd1,
        OP_SETPC   = 3'd2,
        OP_SWAPPC  = 3'd3,
        OP_TRAPRET = 3'd4,
        OP_JOIN    = 3'd5
    } pcj_op_e;
endpackage

// File: rtl/pcj_stack_rf.sv
// Module: word array holding saved stack slots (four 32-bit words per slot).
// Assumes: one write port (test preload) and one 64-bit pair read port;
// a pair index p returns {word 2p+1, word 2p}. The array is not reset.
module pcj_stack_rf #(
    parameter int CSP_W = 3
) (
    input  logic                  clk,
    input  logic                  wr_en,
    input  logic [CSP_W+1:0]      wr_addr,
    input  logic [31:0]           wr_data,
    input  logic [CSP_W:0]        rd_pair,
    output logic [63:0]           rd_data
);
    localparam int SLOTS = 2 ** CSP_W;
    localparam int WORDS = SLOTS * 4;

    logic [31:0] mem [WORDS];

    // Purpose: store a preload word.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Purpose: assemble a 64-bit pair, low word at the even index.
    always_comb begin
        rd_data = {mem[{rd_pair, 1'b1}], mem[{rd_pair, 1'b0}]};
    end
endmodule

// File: rtl/pcj_join_fsm.sv
// Module: control-stack pointer and two-cycle join pop sequencer.
// Assumes: join_go is only asserted when idle; the mask pair is read in the
// first pop cycle and the PC pair in the second, both at the decremented pointer.
module pcj_join_fsm #(
    parameter int CSP_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               join_go,
    input  logic [63:0]        join_src,
    input  logic               csp_ld_en,
    input  logic [CSP_W-1:0]   csp_ld_val,
    input  logic [63:0]        rd_data,
    output logic [CSP_W:0]     rd_pair,
    output logic               busy,
    output logic [CSP_W-1:0]   csp,
    output logic [63:0]        exec_data,
    output logic               exec_we,
    output logic               underflow,
    output logic               join_pass,
    output logic               pop_load,
    output logic [63:0]        pop_pc
);
    typedef enum logic [1:0] {J_IDLE, J_MASK, J_PC} jstate_e;
    jstate_e state;

    logic match;

    // Purpose: full-width compare of operand against the pointer.
    always_comb begin
        match     = (join_src == {{(64-CSP_W){1'b0}}, csp});
        join_pass = join_go && match;
        busy      = (state != J_IDLE);
        pop_load  = (state == J_PC);
        pop_pc    = rd_data;
        rd_pair   = {csp, (state == J_PC)};
    end

    // Purpose: pointer update, pop sequencing and mask/underflow pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= J_IDLE;
            csp       <= '0;
            exec_data <= '0;
            exec_we   <= 1'b0;
            underflow <= 1'b0;
        end else begin
            exec_we   <= 1'b0;
            underflow <= 1'b0;
            case (state)
                J_IDLE: begin
                    if (join_go && !match) begin
                        if (csp == '0) begin
                            underflow <= 1'b1;
                        end else begin
                            csp   <= csp - 1'b1;
                            state <= J_MASK;
                        end
                    end else if (csp_ld_en) begin
                        csp <= csp_ld_val;
                    end
                end
                J_MASK: begin
                    exec_data <= rd_data;
                    exec_we   <= 1'b1;
                    state     <= J_PC;
                end
                default: state <= J_IDLE;
            endcase
        end
    end

    a_r8_csp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (join_go && !match && csp != '0) |=> (csp == $past(csp) - 1'b1) && busy);

    a_r10_underflow_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> (csp == '0) && !busy);

    a_r7_pass_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        join_pass |=> $stable(csp) && !busy && !exec_we);
endmodule

// File: rtl/pcj_pc_unit.sv
// Module: program counter register and destination result path.
// Assumes: op_go and pop_load are never high together (pop runs only while busy).
module pcj_pc_unit
    import pcj_pkg::*;
#(
    parameter logic [63:0] RESET_PC = 64'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_go,
    input  pcj_op_e     op_code,
    input  logic [63:0] src,
    input  logic [63:0] trap_addr,
    input  logic        join_pass,
    input  logic        pop_load,
    input  logic [63:0] pop_pc,
    output logic [63:0] pc,
    output logic [63:0] dst_data,
    output logic        dst_we
);
    logic [63:0] pc_inc;

    // Purpose: address of the next sequential instruction.
    always_comb pc_inc = pc + PC_STEP;

    // Purpose: select the next PC and register the destination write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc       <= RESET_PC;
            dst_data <= '0;
            dst_we   <= 1'b0;
        end else begin
            dst_we <= 1'b0;
            if (pop_load) begin
                pc <= pop_pc;
            end else if (op_go) begin
                case (op_code)
                    OP_GETPC: begin
                        dst_data <= pc_inc;
                        dst_we   <= 1'b1;
                        pc       <= pc_inc;
                    end
                    OP_SETPC:   pc <= src;
                    OP_SWAPPC: begin
                        dst_data <= pc_inc;
                        dst_we   <= 1'b1;
                        pc       <= src;
                    end
                    OP_TRAPRET: pc <= trap_addr;
                    OP_JOIN:    if (join_pass) pc <= pc_inc;
                    default:    pc <= pc_inc;
                endcase
            end
        end
    end

    a_r3_dst_value: assert property (@(posedge clk) disable iff (!rst_n)
        dst_we |-> (dst_data == $past(pc) + PC_STEP));

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (op_go && (op_code == OP_STEP)) |=> (pc == $past(pc) + PC_STEP));
endmodule

// File: rtl/pc_join_seq.sv
// Module: top of the PC and branch-join sequencer.
// Assumes: op_valid is sampled each cycle and dropped while busy; the
// preload port is for test use and loads the pointer only when idle and quiet.
module pc_join_seq
    import pcj_pkg::*;
#(
    parameter int          CSP_W    = 3,
    parameter logic [63:0] RESET_PC = 64'h0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [2:0]         op_code,
    input  logic [63:0]        src_operand,
    input  logic [63:0]        trap_addr,
    input  logic               pre_we,
    input  logic [CSP_W+1:0]   pre_addr,
    input  logic [31:0]        pre_data,
    input  logic               pre_csp_we,
    input  logic [CSP_W-1:0]   pre_csp,
    output logic [63:0]        pc,
    output logic [63:0]        dst_data,
    output logic               dst_we,
    output logic [63:0]        exec_data,
    output logic               exec_we,
    output logic [CSP_W-1:0]   csp,
    output logic               busy,
    output logic               underflow
);
    logic          op_go, join_go, csp_ld_en;
    logic          join_pass, pop_load;
    logic [63:0]   pop_pc, rd_data;
    logic [CSP_W:0] rd_pair;
    pcj_op_e       op_e;

    // Purpose: accept strobes only when idle and decode the join.
    always_comb begin
        op_e      = pcj_op_e'(op_code);
        op_go     = op_valid && !busy;
        join_go   = op_go && (op_e == OP_JOIN);
        csp_ld_en = pre_csp_we && !busy && !op_valid;
    end

    pcj_stack_rf #(.CSP_W(CSP_W)) u_rf (
        .clk(clk), .wr_en(pre_we), .wr_addr(pre_addr), .wr_data(pre_data),
        .rd_pair(rd_pair), .rd_data(rd_data)
    );

    pcj_join_fsm #(.CSP_W(CSP_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .join_go(join_go), .join_src(src_operand),
        .csp_ld_en(csp_ld_en), .csp_ld_val(pre_csp), .rd_data(rd_data),
        .rd_pair(rd_pair), .busy(busy), .csp(csp), .exec_data(exec_data),
        .exec_we(exec_we), .underflow(underflow), .join_pass(join_pass),
        .pop_load(pop_load), .pop_pc(pop_pc)
    );

    pcj_pc_unit #(.RESET_PC(RESET_PC)) u_pc (
        .clk(clk), .rst_n(rst_n), .op_go(op_go), .op_code(op_e),
        .src(src_operand), .trap_addr(trap_addr), .join_pass(join_pass),
        .pop_load(pop_load), .pop_pc(pop_pc), .pc(pc), .dst_data(dst_data),
        .dst_we(dst_we)
    );

    a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pop_load) |=> $stable(pc) && !dst_we);

    a_r8_pop_done: assert property (@(posedge clk) disable iff (!rst_n)
        exec_we |=> !busy);
endmodule

// File: tb/sim_pc_join_seq.sv
module sim_pc_join_seq;
    localparam int          CSP_W = 3;
    localparam logic [63:0] RPC   = 64'h100;

    logic clk = 0, rst_n = 0;
    logic op_valid = 0;
    logic [2:0] op_code = 0;
    logic [63:0] src_operand = 0, trap_addr = 0;
    logic pre_we = 0, pre_csp_we = 0;
    logic [CSP_W+1:0] pre_addr = 0;
    logic [31:0] pre_data = 0;
    logic [CSP_W-1:0] pre_csp = 0;
    logic [63:0] pc, dst_data, exec_data;
    logic dst_we, exec_we, busy, underflow;
    logic [CSP_W-1:0] csp;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [63:0] exp_pc;

    always #2.5 clk = ~clk;

    pc_join_seq #(.CSP_W(CSP_W), .RESET_PC(RPC)) u0 (.*);

    function automatic logic [31:0] word_val(int i);
        return 32'h5A00_0000 + i * 32'h0001_0203;
    endfunction

    function automatic logic [63:0] pair_val(int lo);
        return {word_val(lo + 1), word_val(lo)};
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one strobe at a falling edge; return after the accepting edge.
    task automatic issue(logic [2:0] code, logic [63:0] src);
        @(negedge clk);
        op_valid = 1; op_code = code; src_operand = src;
        @(negedge clk);
        op_valid = 0;
    endtask

    task automatic t_reset();
        chk("R1 pc", pc, RPC);
        chk("R1 csp", 64'(csp), 0);
        chk("R1 flags", {60'd0, dst_we, exec_we, busy, underflow}, 0);
        exp_pc = RPC;
    endtask

    task automatic t_step();
        issue(3'd0, 64'hFFFF);
        exp_pc += 4;
        chk("R2 step code0", pc, exp_pc);
        issue(3'd6, 0);
        exp_pc += 4;
        chk("R2 step code6", pc, exp_pc);
        issue(3'd7, 0);
        exp_pc += 4;
        chk("R2 step code7", pc, exp_pc);
        chk("R2 no write", {62'd0, dst_we, exec_we}, 0);
    endtask

    task automatic t_set_get();
        issue(3'd2, 64'h1000);
        chk("R4 set pc", pc, 64'h1000);
        chk("R4 no dst", 64'(dst_we), 0);
        issue(3'd1, 64'h0);
        chk("R3 dst_we", 64'(dst_we), 1);
        chk("R3 dst_data", dst_data, 64'h1004);
        chk("R3 pc", pc, 64'h1004);
        @(negedge clk);
        chk("R3 pulse ends", 64'(dst_we), 0);
    endtask

    task automatic t_swap();
        issue(3'd3, 64'hDEAD_BEEF_0000_0100);
        chk("R5 dst_we", 64'(dst_we), 1);
        chk("R5 dst_data", dst_data, 64'h1008);
        chk("R5 pc", pc, 64'hDEAD_BEEF_0000_0100);
    endtask

    task automatic t_trap();
        trap_addr = 64'h8000_0000_0000_0040;
        issue(3'd4, 64'h1234);
        exp_pc = 64'h8000_0000_0000_0040;
        chk("R6 pc", pc, exp_pc);
    endtask

    task automatic t_preload();
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            pre_we = 1; pre_addr = i[CSP_W+1:0]; pre_data = word_val(i);
        end
        @(negedge clk);
        pre_we = 0; pre_csp_we = 1; pre_csp = 3'd7;
        @(negedge clk);
        pre_csp_we = 0;
        chk("R11 csp load", 64'(csp), 7);
    endtask

    task automatic t_join_equal();
        issue(3'd5, 64'd7);
        exp_pc += 4;
        chk("R7 pc", pc, exp_pc);
        chk("R7 csp", 64'(csp), 7);
        chk("R7 no pop", {62'd0, busy, exec_we}, 0);
    endtask

    // Mismatching join; read-PC strobes are held high during the pop (R9).
    task automatic t_join_pop(string req, logic [63:0] src, int slot);
        @(negedge clk);
        op_valid = 1; op_code = 3'd5; src_operand = src;
        @(negedge clk);
        op_code = 3'd1;
        chk({req, " csp dec"}, 64'(csp), slot);
        chk({req, " busy"}, 64'(busy), 1);
        chk({req, " pc held"}, pc, exp_pc);
        @(negedge clk);
        chk({req, " exec_we"}, 64'(exec_we), 1);
        chk({req, " exec_data"}, exec_data, pair_val(4 * slot));
        chk("R9 no dst while busy", 64'(dst_we), 0);
        chk("R9 pc held while busy", pc, exp_pc);
        @(negedge clk);
        op_valid = 0;
        exp_pc = pair_val(4 * slot + 2);
        chk({req, " pc popped"}, pc, exp_pc);
        chk({req, " idle"}, {62'd0, busy, exec_we}, 0);
        chk("R9 no dst after pop", 64'(dst_we), 0);
    endtask

    task automatic t_underflow();
        @(negedge clk);
        pre_csp_we = 1; pre_csp = 3'd0;
        @(negedge clk);
        pre_csp_we = 0;
        chk("R11 csp zero", 64'(csp), 0);
        issue(3'd5, 64'd1);
        chk("R10 underflow", 64'(underflow), 1);
        chk("R10 pc", pc, exp_pc);
        chk("R10 csp", 64'(csp), 0);
        chk("R10 not busy", 64'(busy), 0);
        @(negedge clk);
        chk("R10 pulse ends", 64'(underflow), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_step();
        t_set_get();
        t_swap();
        t_trap();
        t_preload();
        t_join_equal();
        t_join_pop("R8", 64'd0, 6);
        t_join_pop("R12", 64'h1_0000_0006, 5);
        t_underflow();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule